// File: doc/BRIEF.md
# Package Performance-Ratio Resolver

This block turns per-module performance requests into one clock ratio that the whole package runs at. Each dual-core module offers an 8-bit requested ratio and a valid flag. The resolver picks the most demanding valid request and limits it to the legal window, from the maximum-efficiency ratio up to the turbo limit. It then applies any active hardware ceilings from the thermal, power-limit and package-idle paths. The result is registered and driven to every core at once.

A software-disable input makes the block ignore every module request and fall back to the guaranteed ratio. The hardware ceilings still work while software requests are off. A one-cycle strobe marks each change of the applied ratio. A lock output rises at the first clock after reset and stays high, so that every core follows the single shared target and no core can drift to a different ratio.

Top module: `pstate_resolver`

## Requirements
- R1: While reset is held, `target_ratio` is 0 and `ratio_chg` and `ratio_lock` are low.
- R2: `ratio_lock` rises at the first clock edge after reset is released and then stays high.
- R3: With software requests enabled, the request path selects the largest ratio among the modules whose valid bit is 1. Module i occupies bits [i*8+7 : i*8] of `mod_req_ratio`.
- R4: A module with its valid bit at 0 has no effect. When no module is valid, the request path uses `cfg_guar_ratio`.
- R5: While `sw_req_dis` is 1, every module request is ignored and the request path uses `cfg_guar_ratio`.
- R6: The request path result is capped at `cfg_turbo_max` and raised to at least `cfg_eff_ratio`.
- R7: Each active hardware input (thermal, power-limit, idle) sets a ceiling, and the applied ratio is never above the lowest active ceiling. This holds whatever the value of `sw_req_dis`.
- R8: The applied ratio is never below `cfg_eff_ratio`. If the ceilings call for a lower ratio, the floor wins.
- R9: The output is registered. An input change shows up on `target_ratio` one clock edge later, and not before that edge.
- R10: `ratio_chg` is high for exactly the cycle after an edge at which `target_ratio` took a new value. It stays low on the first load after reset, and `target_ratio` holds while no change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_req_ratio | input | N_MOD*RW | Packed per-module requested ratios |
| mod_req_vld | input | N_MOD | Per-module request valid |
| sw_req_dis | input | 1 | Ignore all software (module) requests |
| cfg_turbo_max | input | RW | Highest legal ratio |
| cfg_guar_ratio | input | RW | Guaranteed ratio, used as the default request |
| cfg_eff_ratio | input | RW | Maximum-efficiency ratio, the floor |
| therm_act | input | 1 | Thermal ceiling active |
| therm_ceil | input | RW | Thermal ceiling ratio |
| plim_act | input | 1 | Power-limit ceiling active |
| plim_ceil | input | RW | Power-limit ceiling ratio |
| idle_act | input | 1 | Package-idle ceiling active |
| idle_ceil | input | RW | Package-idle ceiling ratio |
| target_ratio | output | RW | Package-wide applied ratio |
| ratio_chg | output | 1 | One-cycle strobe on a change of the applied ratio |
| ratio_lock | output | 1 | All cores locked to the shared ratio |

## Verification
The assertions check on every cycle that lock stays high once it has risen, that the ratio never falls below the floor, and that it never exceeds the turbo cap or the thermal ceiling unless the floor takes over. They also check that the strobe matches an actual change of the target, and that the guaranteed default is used whenever software requests are disabled and no ceiling is active. Only the bench scenarios show that the right module wins the maximum for each valid mask, that invalid modules are ignored, that the lowest of several active ceilings is the one applied, and that the output lags its inputs by exactly one edge.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
   // Structure used to reduce the module requests to one maximum
   typedef enum logic {
      REDUCE_CHAIN = 1'b0,
      REDUCE_TREE  = 1'b1
   } reduce_e;

   // Number of hardware ceiling sources; vector order is thermal, power-limit, idle
   localparam int LIM_COUNT = 3;
endpackage

// File: rtl/pstate_req_max.sv
module pstate_req_max
   import pstate_pkg::*;
#(
   parameter int      N_MOD = 4,
   parameter int      RW    = 8,
   parameter reduce_e STYLE = REDUCE_TREE
) (
   input  logic [N_MOD*RW-1:0] req_ratio,
   input  logic [N_MOD-1:0]    req_vld,
   output logic                any_vld,
   output logic [RW-1:0]       max_ratio
);
   generate
      if (STYLE == REDUCE_TREE) begin : g_tree
         localparam int LEAVES = 1 << $clog2(N_MOD);
         localparam int NODES  = 2 * LEAVES - 1;
         logic [RW-1:0] nval [NODES];
         logic          nvld [NODES];

         always_comb begin
            for (int i = 0; i < LEAVES; i++) begin
               if (i < N_MOD) begin
                  nval[LEAVES-1+i] = req_ratio[i*RW +: RW];
                  nvld[LEAVES-1+i] = req_vld[i];
               end else begin
                  nval[LEAVES-1+i] = '0;
                  nvld[LEAVES-1+i] = 1'b0;
               end
            end
            for (int j = LEAVES - 2; j >= 0; j--) begin
               nvld[j] = nvld[2*j+1] | nvld[2*j+2];
               if (nvld[2*j+1] && nvld[2*j+2])
                  nval[j] = (nval[2*j+1] >= nval[2*j+2]) ? nval[2*j+1] : nval[2*j+2];
               else if (nvld[2*j+1])
                  nval[j] = nval[2*j+1];
               else if (nvld[2*j+2])
                  nval[j] = nval[2*j+2];
               else
                  nval[j] = '0;
            end
         end

         assign any_vld   = nvld[0];
         assign max_ratio = nval[0];
      end else begin : g_chain
         logic [RW-1:0] best;
         logic          seen;

         always_comb begin
            best = '0;
            seen = 1'b0;
            for (int i = 0; i < N_MOD; i++) begin
               if (req_vld[i] && (!seen || (req_ratio[i*RW +: RW] > best))) begin
                  best = req_ratio[i*RW +: RW];
                  seen = 1'b1;
               end
            end
         end

         assign any_vld   = seen;
         assign max_ratio = best;
      end
   endgenerate
endmodule

// File: rtl/pstate_hw_ceiling.sv
module pstate_hw_ceiling #(
   parameter int NLIM = 3,
   parameter int RW   = 8
) (
   input  logic [NLIM-1:0]    lim_act,
   input  logic [NLIM*RW-1:0] lim_ceil,
   output logic               any_act,
   output logic [RW-1:0]      low_ceil
);
   always_comb begin
      any_act  = 1'b0;
      low_ceil = '1;
      for (int k = 0; k < NLIM; k++) begin
         if (lim_act[k]) begin
            any_act = 1'b1;
            if (lim_ceil[k*RW +: RW] < low_ceil)
               low_ceil = lim_ceil[k*RW +: RW];
         end
      end
   end
endmodule

// File: rtl/pstate_apply.sv
module pstate_apply #(
   parameter int RW = 8
) (
   input  logic          sw_dis,
   input  logic          any_req,
   input  logic [RW-1:0] req_max,
   input  logic [RW-1:0] cfg_turbo,
   input  logic [RW-1:0] cfg_guar,
   input  logic [RW-1:0] cfg_eff,
   input  logic          any_lim,
   input  logic [RW-1:0] lim_ceil,
   output logic [RW-1:0] next_ratio
);
   logic [RW-1:0] base, capped, limited;

   always_comb begin
      // request path: module maximum or guaranteed default
      base    = (sw_dis || !any_req) ? cfg_guar : req_max;
      capped  = (base > cfg_turbo) ? cfg_turbo : base;
      // hardware ceiling, then the efficiency floor has the last word
      limited = (any_lim && (lim_ceil < capped)) ? lim_ceil : capped;
      next_ratio = (limited < cfg_eff) ? cfg_eff : limited;
   end
endmodule

// File: rtl/pstate_resolver.sv
module pstate_resolver
   import pstate_pkg::*;
#(
   parameter int      N_MOD = 4,
   parameter int      RW    = 8,
   parameter reduce_e STYLE = REDUCE_TREE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_MOD*RW-1:0] mod_req_ratio,
   input  logic [N_MOD-1:0]    mod_req_vld,
   input  logic                sw_req_dis,
   input  logic [RW-1:0]       cfg_turbo_max,
   input  logic [RW-1:0]       cfg_guar_ratio,
   input  logic [RW-1:0]       cfg_eff_ratio,
   input  logic                therm_act,
   input  logic [RW-1:0]       therm_ceil,
   input  logic                plim_act,
   input  logic [RW-1:0]       plim_ceil,
   input  logic                idle_act,
   input  logic [RW-1:0]       idle_ceil,
   output logic [RW-1:0]       target_ratio,
   output logic                ratio_chg,
   output logic                ratio_lock
);
   generate
      if (N_MOD < 1) begin : g_bad_nmod
         $error("pstate_resolver: N_MOD must be at least 1");
      end
      if (RW < 2 || RW > 16) begin : g_bad_rw
         $error("pstate_resolver: RW must lie in 2..16");
      end
   endgenerate

   logic                  any_req;
   logic [RW-1:0]         req_max;
   logic [LIM_COUNT-1:0]  lim_act;
   logic [LIM_COUNT*RW-1:0] lim_ceil;
   logic                  any_lim;
   logic [RW-1:0]         low_ceil;
   logic [RW-1:0]         next_ratio;
   logic [RW-1:0]         tgt_q;
   logic                  chg_q;
   logic                  lock_q;

   assign lim_act  = {idle_act, plim_act, therm_act};
   assign lim_ceil = {idle_ceil, plim_ceil, therm_ceil};

   pstate_req_max #(.N_MOD(N_MOD), .RW(RW), .STYLE(STYLE)) u_req_max (
      .req_ratio (mod_req_ratio),
      .req_vld   (mod_req_vld),
      .any_vld   (any_req),
      .max_ratio (req_max)
   );

   pstate_hw_ceiling #(.NLIM(LIM_COUNT), .RW(RW)) u_ceiling (
      .lim_act  (lim_act),
      .lim_ceil (lim_ceil),
      .any_act  (any_lim),
      .low_ceil (low_ceil)
   );

   pstate_apply #(.RW(RW)) u_apply (
      .sw_dis     (sw_req_dis),
      .any_req    (any_req),
      .req_max    (req_max),
      .cfg_turbo  (cfg_turbo_max),
      .cfg_guar   (cfg_guar_ratio),
      .cfg_eff    (cfg_eff_ratio),
      .any_lim    (any_lim),
      .lim_ceil   (low_ceil),
      .next_ratio (next_ratio)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q  <= '0;
         chg_q  <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         tgt_q  <= next_ratio;
         chg_q  <= lock_q && (next_ratio != tgt_q);
         lock_q <= 1'b1;
      end
   end

   assign target_ratio = tgt_q;
   assign ratio_chg    = chg_q;
   assign ratio_lock   = lock_q;
endmodule

// File: rtl/pstate_resolver_chk.sv
module pstate_resolver_chk #(
   parameter int N_MOD = 4,
   parameter int RW    = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sw_req_dis,
   input logic [RW-1:0] cfg_turbo_max,
   input logic [RW-1:0] cfg_guar_ratio,
   input logic [RW-1:0] cfg_eff_ratio,
   input logic          therm_act,
   input logic [RW-1:0] therm_ceil,
   input logic          plim_act,
   input logic          idle_act,
   input logic [RW-1:0] target_ratio,
   input logic          ratio_chg,
   input logic          ratio_lock
);
   // inputs as seen at the previous edge
   logic          q_dis, q_hw;
   logic [RW-1:0] q_turbo, q_guar, q_eff, q_therm;
   logic [RW-1:0] dflt;

   always_ff @(posedge clk) begin
      q_dis   <= sw_req_dis;
      q_hw    <= therm_act | plim_act | idle_act;
      q_turbo <= cfg_turbo_max;
      q_guar  <= cfg_guar_ratio;
      q_eff   <= cfg_eff_ratio;
      q_therm <= therm_ceil;
   end

   always_comb begin
      dflt = (q_guar > q_turbo) ? q_turbo : q_guar;
      if (dflt < q_eff) dflt = q_eff;
   end

   // R1: outputs quiet while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (target_ratio == '0 && !ratio_chg && !ratio_lock)
            else $error("R1 reset outputs not quiet");
      end
   end

   p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ratio_lock) |-> ratio_lock);

   p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_lock |-> target_ratio >= q_eff);

   p_turbo_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_lock |-> (target_ratio <= q_turbo || target_ratio == q_eff));

   p_therm_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_lock && $past(therm_act)) |-> (target_ratio <= q_therm || target_ratio == q_eff));

   p_sw_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_lock && q_dis && !q_hw) |-> target_ratio == dflt);

   p_strobe_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_lock && $past(ratio_lock)) |-> (ratio_chg == (target_ratio != $past(target_ratio))));

   p_first_load_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_lock && !$past(ratio_lock)) |-> !ratio_chg);
endmodule

bind pstate_resolver pstate_resolver_chk #(.N_MOD(N_MOD), .RW(RW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sw_req_dis     (sw_req_dis),
   .cfg_turbo_max  (cfg_turbo_max),
   .cfg_guar_ratio (cfg_guar_ratio),
   .cfg_eff_ratio  (cfg_eff_ratio),
   .therm_act      (therm_act),
   .therm_ceil     (therm_ceil),
   .plim_act       (plim_act),
   .idle_act       (idle_act),
   .target_ratio   (target_ratio),
   .ratio_chg      (ratio_chg),
   .ratio_lock     (ratio_lock)
);

// File: tb/pstate_resolver_test.sv
`timescale 1ns/1ps
module pstate_resolver_test;
   localparam int N = 4;
   localparam int W = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [N*W-1:0] req;
   logic [N-1:0]  vld;
   logic          dis;
   logic [W-1:0]  turbo, guar, eff;
   logic          ta, pa, ia;
   logic [W-1:0]  tc, pc, ic;
   logic [W-1:0]  target;
   logic          chg, lock;

   pstate_resolver #(.N_MOD(N), .RW(W)) uut (
      .clk(clk), .rst_n(rst_n), .mod_req_ratio(req), .mod_req_vld(vld),
      .sw_req_dis(dis), .cfg_turbo_max(turbo), .cfg_guar_ratio(guar),
      .cfg_eff_ratio(eff), .therm_act(ta), .therm_ceil(tc), .plim_act(pa),
      .plim_ceil(pc), .idle_act(ia), .idle_ceil(ic), .target_ratio(target),
      .ratio_chg(chg), .ratio_lock(lock)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   int rq [N];
   int ceil_v [3];
   int prev_exp;

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference: max of valid, default, cap, ceiling, floor
   function automatic int model(int mask, int sw, int ha, output string tag);
      int best, base, capv, lim, res;
      bit any;
      any = 0; best = 0;
      for (int i = 0; i < N; i++)
         if (mask[i] && (!any || rq[i] > best)) begin best = rq[i]; any = 1; end
      base = (sw != 0 || !any) ? int'(guar) : best;
      capv = (base > int'(turbo)) ? int'(turbo) : base;
      lim = 255;
      for (int k = 0; k < 3; k++)
         if (ha[k] && ceil_v[k] < lim) lim = ceil_v[k];
      res = (capv < lim) ? capv : lim;
      if (res < int'(eff)) res = int'(eff);
      if (ha != 0 && lim < capv) tag = (lim < int'(eff)) ? "R8" : "R7";
      else if (base < int'(eff) || base > int'(turbo)) tag = "R6";
      else if (sw != 0) tag = "R5";
      else if (!any) tag = "R4";
      else tag = "R3";
      return res;
   endfunction

   task automatic drive(int mask, int sw, int ha);
      for (int i = 0; i < N; i++) req[i*W +: W] = W'(rq[i]);
      vld = N'(mask);
      dis = sw[0];
      ta = ha[0]; pa = ha[1]; ia = ha[2];
      tc = W'(ceil_v[0]); pc = W'(ceil_v[1]); ic = W'(ceil_v[2]);
   endtask

   // called at a falling edge; one clock per step
   task automatic step(int mask, int sw, int ha);
      string tag;
      int exp;
      drive(mask, sw, ha);
      #1 check("R9 before edge", int'(target), prev_exp);
      @(posedge clk);
      @(negedge clk);
      exp = model(mask, sw, ha, tag);
      check(tag, int'(target), exp);
      check("R10 strobe", int'(chg), (exp != prev_exp) ? 1 : 0);
      check("R2 lock held", int'(lock), 1);
      prev_exp = exp;
   endtask

   initial begin
      string t0;
      eff = 8'd8; guar = 8'd20; turbo = 8'd30;
      ceil_v[0] = 25; ceil_v[1] = 12; ceil_v[2] = 5;
      for (int i = 0; i < N; i++) rq[i] = 10 + i;
      drive(4'hF, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 target", int'(target), 0);
      check("R1 strobe", int'(chg), 0);
      check("R1 lock", int'(lock), 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      prev_exp = model(4'hF, 0, 0, t0);
      check("R2 lock rise", int'(lock), 1);
      check("R10 first load quiet", int'(chg), 0);
      check("R3 first load", int'(target), prev_exp);

      // repeat the same inputs: no strobe, value held
      step(4'hF, 0, 0);

      // near-exhaustive sweep over masks, disable, ceilings and request sets
      for (int seed = 0; seed < 6; seed++) begin
         for (int i = 0; i < N; i++) rq[i] = (seed * 11 + i * 9 + 3) % 40;
         for (int mask = 0; mask < 16; mask++)
            for (int sw = 0; sw < 2; sw++)
               for (int ha = 0; ha < 8; ha++)
                  step(mask, sw, ha);
      end

      // degenerate window: every path collapses to one ratio
      eff = 8'd10; guar = 8'd10; turbo = 8'd10;
      for (int mask = 0; mask < 16; mask++) step(mask, mask & 1, mask >> 1);

      // equal requests on all modules, guaranteed above turbo
      eff = 8'd4; guar = 8'd50; turbo = 8'd40;
      for (int i = 0; i < N; i++) rq[i] = 33;
      step(4'hF, 0, 0);
      step(4'h0, 0, 0);
      step(4'h5, 1, 0);
      step(4'h5, 1, 3'b010);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule